// File: doc/BRIEF.md
# Weighted Round-Robin Output Queue Scheduler

This block chooses which output queue of a single port is served next. The port owns up to `NQ` queues, by default 32, and `num_q` sets how many of them are in use. Each queue holds a 4-bit priority code, written through a simple configuration strobe. Each queue also has a pending-work flag. Codes 0 to 8 are weights. Code 9 places the queue in a strict-priority group. That group must be a contiguous run starting at queue 0.

Every clock the scheduler samples the pending flags. A pending strict queue is always served first, and the lowest such queue wins. Otherwise the scheduler serves weighted queues across a cycle of eight rounds. Each weight becomes an 8-bit round-enable pattern with its bits spread evenly, so service stays proportional to weight.

The registered outputs are:
- a grant flag and a queue index;
- two marker flags: one says the granted queue is the port's last queue, the other says it is the last queue of the strict group;
- a registered configuration error flag.

Priorities can be rewritten while traffic is flowing.

Top module: `wrr_qsched`

## Requirements
- R1: Each weight code becomes a round-enable mask, with bit r enabling round r: 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7F, 8→0xFF. A continuously pending weighted queue is granted once in every round whose bit is set. With queue 0 at code 8 and queue 1 at code 1, both always pending, 170 cycles hold 80 grants of queue 0 and 10 of queue 1.
- R2: A queue with code 0 is never granted.
- R3: Code 9 marks a strict queue, but only inside the unbroken run of code-9 queues that begins at queue 0. When any such queue is pending and active, the lowest-numbered one is granted, ahead of all weighted queues. Strict grants leave the round, served set and pointer unchanged.
- R4: `cfg_err` is high when either condition holds among active queues: a code from 10 to 15, or a code-9 queue outside the leading run. It follows the priority registers with one cycle of latency, and inactive queues have no effect on it. An out-of-range code, or a code 9 outside the run, is scheduled as a weighted queue with mask 0xFF.
- R5: A 3-bit round counter starts at 0. A weighted queue is eligible in round r when all of these hold: it is pending, active and not strict; bit r of its mask is set; and it has not yet been granted in the current round. In a cycle with no strict grant and no eligible queue, there is no grant. In that cycle the round counter increments modulo 8 and the served set clears.
- R6: The weighted grant is the first eligible queue found by searching upward from one past the previous weighted grant, wrapping at `NQ`. The search starts at queue 0 after reset.
- R7: A queue is active when its index is below `num_q`. If no active queue is pending, `grant_vld` is low in the next cycle. A queue that is not active is never granted.
- R8: With a grant, `grant_tail` is high exactly when `grant_q` equals `num_q`-1. `grant_stail` is high exactly when `grant_q` is the highest queue of the leading strict run. Both are low when there is no grant.
- R9: A configuration write at one clock edge changes the scheduling decisions taken from the next edge on, with no reset or pause needed.
- R10: A synchronous reset clears `grant_vld`, `cfg_err`, the round counter, the served set and the pointer. It also sets every priority code to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Priority write strobe |
| cfg_qid | input | QW | Queue index of the write |
| cfg_prio | input | 4 | Priority code to store (0-8 weight, 9 strict) |
| num_q | input | QW+1 | Number of queues in use |
| pend | input | NQ | Per-queue pending-work flags |
| grant_vld | output | 1 | A queue is granted this cycle |
| grant_q | output | QW | Index of the granted queue |
| grant_tail | output | 1 | Granted queue is the last active queue |
| grant_stail | output | 1 | Granted queue ends the strict group |
| cfg_err | output | 1 | Priority setup is invalid |

## Verification
The assertions treat `pend` and `num_q` as free to change on every cycle. They assume the configuration port carries an in-range queue index, which its width guarantees. They also take for granted that the strict group is the leading run of code-9 queues that the design itself computes.

The random stimulus keeps `num_q` between 1 and `NQ`, and redraws the pending flags every cycle. Most configuration writes carry legal codes 0 to 9. About one in eight carries an illegal code, so error cases and broken strict groups occur without swamping the weighted schedule.

// File: rtl/wrr_pkg.sv
`timescale 1ns/1ps
package wrr_pkg;
  localparam int PRIO_W      = 4;
  localparam int RND_N       = 8;
  localparam int RW          = $clog2(RND_N);
  localparam int PRIO_STRICT = 9;
  localparam int PRIO_TOPW   = 8;

  // weight code to evenly spread round-enable pattern
  function automatic logic [RND_N-1:0] prio_mask(input logic [PRIO_W-1:0] p);
    logic [RND_N-1:0] m;
    case (p)
      4'd0:    m = 8'h00;
      4'd1:    m = 8'h01;
      4'd2:    m = 8'h11;
      4'd3:    m = 8'h49;
      4'd4:    m = 8'h55;
      4'd5:    m = 8'h57;
      4'd6:    m = 8'h77;
      4'd7:    m = 8'h7F;
      default: m = 8'hFF; // full weight, strict and illegal codes
    endcase
    return m;
  endfunction

  function automatic logic prio_bad(input logic [PRIO_W-1:0] p);
    return p > PRIO_W'(PRIO_STRICT);
  endfunction
endpackage

// File: rtl/wrr_prio_store.sv
`timescale 1ns/1ps
module wrr_prio_store import wrr_pkg::*; #(
  parameter int NQ = 32,
  localparam int QW = $clog2(NQ)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [QW-1:0]               cfg_qid,
  input  logic [PRIO_W-1:0]           cfg_prio,
  output logic [NQ-1:0][RND_N-1:0]    mask,
  output logic [NQ-1:0]               strict_raw,
  output logic [NQ-1:0]               bad
);
  logic [PRIO_W-1:0] prio_q [NQ];

  for (genvar g = 0; g < NQ; g++) begin : g_q
    always_ff @(posedge clk) begin
      if (rst)
        prio_q[g] <= PRIO_W'(PRIO_TOPW);
      else if (cfg_we && cfg_qid == QW'(g))
        prio_q[g] <= cfg_prio;
    end
    assign mask[g]       = prio_mask(prio_q[g]);
    assign strict_raw[g] = (prio_q[g] == PRIO_W'(PRIO_STRICT));
    assign bad[g]        = prio_bad(prio_q[g]);
  end
endmodule

// File: rtl/wrr_cfg_check.sv
`timescale 1ns/1ps
module wrr_cfg_check #(
  parameter int NQ = 32
) (
  input  logic [NQ-1:0] strict_raw,
  input  logic [NQ-1:0] bad,
  input  logic [NQ-1:0] active,
  output logic [NQ-1:0] lead_strict,
  output logic [NQ-1:0] stail_vec,
  output logic          cfg_bad
);
  logic [NQ-1:0] s_act;
  logic [NQ-1:0] s_inc;

  assign s_act = strict_raw & active;
  assign s_inc = s_act + NQ'(1);
  // trailing run of ones starting at queue 0
  assign lead_strict = s_act & ~s_inc;
  assign stail_vec   = lead_strict & ~(lead_strict >> 1);
  assign cfg_bad     = (|(s_act & ~lead_strict)) | (|(bad & active));
endmodule

// File: rtl/wrr_rr_pick.sv
`timescale 1ns/1ps
module wrr_rr_pick #(
  parameter int NQ = 32,
  localparam int QW = $clog2(NQ)
) (
  input  logic [NQ-1:0] req,
  input  logic [QW-1:0] start,
  output logic          found,
  output logic [QW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < NQ; k++) begin
      int j;
      j = int'(start) + k;
      if (j >= NQ) j = j - NQ;
      if (!found && req[j]) begin
        found = 1'b1;
        idx   = j[QW-1:0];
      end
    end
  end
endmodule

// File: rtl/wrr_qsched.sv
`timescale 1ns/1ps
module wrr_qsched import wrr_pkg::*; #(
  parameter int NQ = 32,
  localparam int QW = $clog2(NQ),
  localparam int NW = QW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [QW-1:0]     cfg_qid,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [NW-1:0]     num_q,
  input  logic [NQ-1:0]     pend,
  output logic              grant_vld,
  output logic [QW-1:0]     grant_q,
  output logic              grant_tail,
  output logic              grant_stail,
  output logic              cfg_err
);
  logic [NQ-1:0][RND_N-1:0] mask;
  logic [NQ-1:0] strict_raw, bad, active, lead_strict, stail_vec;
  logic          cfg_bad;
  logic [RW-1:0] round_q;
  logic [QW-1:0] ptr_q;
  logic [NQ-1:0] done_q;
  logic [NQ-1:0] cur_bit, elig, s_req;
  logic          s_found, w_found;
  logic [QW-1:0] s_idx, w_idx;

  wrr_prio_store #(.NQ(NQ)) u_store (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
    .cfg_prio(cfg_prio), .mask(mask), .strict_raw(strict_raw), .bad(bad)
  );

  for (genvar g = 0; g < NQ; g++) begin : g_act
    assign active[g]  = (num_q > NW'(g));
    assign cur_bit[g] = mask[g][round_q];
  end

  wrr_cfg_check #(.NQ(NQ)) u_chk_cfg (
    .strict_raw(strict_raw), .bad(bad), .active(active),
    .lead_strict(lead_strict), .stail_vec(stail_vec), .cfg_bad(cfg_bad)
  );

  assign s_req = pend & active & lead_strict;
  assign elig  = pend & active & ~lead_strict & cur_bit & ~done_q;

  // strict group: lowest index wins, search from queue 0
  wrr_rr_pick #(.NQ(NQ)) u_pick_strict (
    .req(s_req), .start('0), .found(s_found), .idx(s_idx)
  );

  wrr_rr_pick #(.NQ(NQ)) u_pick_wrr (
    .req(elig), .start(ptr_q), .found(w_found), .idx(w_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_vld   <= 1'b0;
      grant_q     <= '0;
      grant_tail  <= 1'b0;
      grant_stail <= 1'b0;
      cfg_err     <= 1'b0;
      round_q     <= '0;
      ptr_q       <= '0;
      done_q      <= '0;
    end else begin
      cfg_err <= cfg_bad;
      if (s_found) begin
        grant_vld   <= 1'b1;
        grant_q     <= s_idx;
        grant_tail  <= (NW'(s_idx) + NW'(1)) == num_q;
        grant_stail <= stail_vec[s_idx];
      end else if (w_found) begin
        grant_vld   <= 1'b1;
        grant_q     <= w_idx;
        grant_tail  <= (NW'(w_idx) + NW'(1)) == num_q;
        grant_stail <= stail_vec[w_idx];
        done_q[w_idx] <= 1'b1;
        ptr_q <= (int'(w_idx) == NQ - 1) ? '0 : w_idx + QW'(1);
      end else begin
        grant_vld   <= 1'b0;
        grant_tail  <= 1'b0;
        grant_stail <= 1'b0;
        round_q     <= round_q + RW'(1);
        done_q      <= '0;
      end
    end
  end
endmodule

// File: rtl/wrr_qsched_chk.sv
`timescale 1ns/1ps
module wrr_qsched_chk #(
  parameter int NQ = 32,
  localparam int QW = $clog2(NQ),
  localparam int NW = QW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [QW-1:0] cfg_qid,
  input logic [3:0]    cfg_prio,
  input logic [NW-1:0] num_q,
  input logic [NQ-1:0] pend,
  input logic          grant_vld,
  input logic [QW-1:0] grant_q,
  input logic [2:0]    round_q,
  input logic [NQ-1:0] lead_strict
);
  logic [NQ-1:0] act_now, pend_p, act_p, zero_vec, zero_p, strict_p;

  for (genvar g = 0; g < NQ; g++) begin : g_a
    assign act_now[g] = (num_q > NW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_p <= '0; act_p <= '0; zero_vec <= '0; zero_p <= '0; strict_p <= '0;
    end else begin
      pend_p   <= pend;
      act_p    <= act_now;
      zero_p   <= zero_vec;
      strict_p <= lead_strict & pend & act_now;
      if (cfg_we) zero_vec[cfg_qid] <= (cfg_prio == 4'd0);
    end
  end

  a_r7_grant_was_pending: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> (pend_p[grant_q] && act_p[grant_q]));

  a_r7_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
    ((pend_p & act_p) == '0) |-> !grant_vld);

  a_r2_zero_never: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> !zero_p[grant_q]);

  a_r3_strict_first: assert property (@(posedge clk) disable iff (rst)
    (strict_p != '0) |-> (grant_vld && strict_p[grant_q] &&
      ((strict_p & ~({NQ{1'b1}} << grant_q)) == '0)));

  a_r5_round_step: assert property (@(posedge clk) disable iff (rst)
    (round_q != $past(round_q)) |-> (round_q == $past(round_q) + 3'd1));

  a_r5_quiet_on_step: assert property (@(posedge clk) disable iff (rst)
    (round_q != $past(round_q)) |-> !grant_vld);
endmodule

bind wrr_qsched wrr_qsched_chk #(.NQ(NQ)) u_sva (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
  .cfg_prio(cfg_prio), .num_q(num_q), .pend(pend), .grant_vld(grant_vld),
  .grant_q(grant_q), .round_q(round_q), .lead_strict(lead_strict)
);

// File: tb/wrr_qsched_tb_top.sv
`timescale 1ns/1ps
module wrr_qsched_tb_top;
  localparam int NQ = 32;
  localparam int QW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [QW-1:0] cfg_qid = '0;
  logic [3:0]    cfg_prio = '0;
  logic [QW:0]   num_q = 6'd32;
  logic [NQ-1:0] pend = '0;
  logic          grant_vld, grant_tail, grant_stail, cfg_err;
  logic [QW-1:0] grant_q;

  wrr_qsched #(.NQ(NQ)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
    .cfg_prio(cfg_prio), .num_q(num_q), .pend(pend),
    .grant_vld(grant_vld), .grant_q(grant_q), .grant_tail(grant_tail),
    .grant_stail(grant_stail), .cfg_err(cfg_err)
  );

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 1'b0;
  bit cnt_en = 1'b0;
  bit ended  = 1'b0;
  int cnt [NQ];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [7:0] w_mask(input logic [3:0] p);
    case (p)
      4'd0: return 8'h00; 4'd1: return 8'h01; 4'd2: return 8'h11;
      4'd3: return 8'h49; 4'd4: return 8'h55; 4'd5: return 8'h57;
      4'd6: return 8'h77; 4'd7: return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  // reference model state and expected outputs
  logic [3:0]    m_prio [NQ];
  int            m_round, m_ptr;
  logic [NQ-1:0] m_done;
  bit            e_vld, e_tail, e_stail, e_err;
  int            e_q, e_kind;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NQ; i++) m_prio[i] = 4'd8;
      m_round = 0; m_ptr = 0; m_done = '0;
      e_vld = 0; e_q = 0; e_tail = 0; e_stail = 0; e_err = 0; e_kind = 10;
    end else begin
      bit inlead, err;
      int last_s, pick;
      logic [NQ-1:0] act, lead;
      logic [7:0] mk;
      inlead = 1; err = 0; last_s = -1; pick = -1;
      for (int i = 0; i < NQ; i++) begin
        act[i]  = (i < int'(num_q));
        lead[i] = 1'b0;
        if (act[i] && m_prio[i] == 4'd9 && inlead) begin
          lead[i] = 1'b1; last_s = i;
        end else inlead = 0;
        if (act[i] && m_prio[i] > 4'd9) err = 1;
        if (act[i] && m_prio[i] == 4'd9 && !lead[i]) err = 1;
      end
      e_err = err;
      for (int i = 0; i < NQ; i++)
        if (pick < 0 && lead[i] && pend[i]) pick = i;
      if (pick >= 0) e_kind = 3;
      else begin
        for (int k = 0; k < NQ; k++) begin
          int j;
          j = (m_ptr + k) % NQ;
          mk = w_mask(m_prio[j]);
          if (pick < 0 && act[j] && !lead[j] && pend[j] && !m_done[j] && mk[m_round])
            pick = j;
        end
        if (pick >= 0) begin
          e_kind = 6; m_done[pick] = 1'b1; m_ptr = (pick + 1) % NQ;
        end else begin
          e_kind  = ((pend & act) != '0) ? 5 : 7;
          m_round = (m_round + 1) % 8; m_done = '0;
        end
      end
      e_vld   = (pick >= 0);
      e_q     = (pick >= 0) ? pick : 0;
      e_tail  = (pick >= 0) && (pick == int'(num_q) - 1);
      e_stail = (pick >= 0) && (pick == last_s);
      if (cfg_we) m_prio[cfg_qid] = cfg_prio;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      string tg;
      tg = (e_kind == 3) ? "R3" : (e_kind == 6) ? "R6" : (e_kind == 5) ? "R5" : "R7";
      chk(cfg_err == e_err, "R4 cfg_err", cfg_err, e_err);
      chk(grant_vld == e_vld, {tg, " grant_vld"}, grant_vld, e_vld);
      if (e_vld) chk(int'(grant_q) == e_q, {tg, " grant_q"}, grant_q, e_q);
      chk(grant_tail == e_tail && grant_stail == e_stail, "R8 tail markers",
          {grant_tail, grant_stail}, {e_tail, e_stail});
    end
    if (cnt_en && grant_vld) cnt[grant_q]++;
  end

  task automatic wr(input int q, input int p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_qid = QW'(q); cfg_prio = 4'(p);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic count_window(input int n);
    for (int i = 0; i < NQ; i++) cnt[i] = 0;
    @(posedge clk); cnt_en = 1'b1;
    repeat (n) @(posedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(grant_vld == 1'b0, "R10 reset grant_vld", grant_vld, 0);
    chk(cfg_err == 1'b0, "R10 reset cfg_err", cfg_err, 0);
    cmp_en = 1'b1;

    // R1: weight 8 against weight 1
    num_q = 6'd2;
    wr(0, 8); wr(1, 1);
    @(negedge clk); pend = 32'h3;
    repeat (20) @(negedge clk);
    count_window(170);
    chk(cnt[0] == 80, "R1 weight8 grants", cnt[0], 80);
    chk(cnt[1] == 10, "R1 weight1 grants", cnt[1], 10);

    // R2: weight 0 is never granted
    wr(1, 0);
    repeat (4) @(negedge clk);
    count_window(40);
    chk(cnt[1] == 0, "R2 weight0 grants", cnt[1], 0);
    chk(cnt[0] == 20, "R2 partner grants", cnt[0], 20);

    // R9: change on the fly
    wr(1, 8);
    repeat (6) @(negedge clk);
    count_window(42);
    chk(cnt[1] == 14, "R9 retuned grants", cnt[1], 14);

    // R3 / R8: strict group at queues 0..1
    num_q = 6'd4;
    wr(0, 9); wr(1, 9); wr(2, 4); wr(3, 8);
    @(negedge clk); pend = 32'hF;
    @(negedge clk);
    count_window(10);
    chk(cnt[0] == 10, "R3 lowest strict wins", cnt[0], 10);
    @(negedge clk); pend = 32'hE;
    @(negedge clk); @(negedge clk);
    chk(grant_vld && grant_q == 5'd1 && grant_stail, "R8 strict tail grant", grant_q, 1);
    @(negedge clk); pend = 32'hC;
    repeat (20) @(negedge clk);

    // R4: broken strict group and illegal codes
    wr(1, 4); wr(2, 9);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R4 non-contiguous strict", cfg_err, 1);
    wr(2, 4);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R4 repaired", cfg_err, 0);
    wr(3, 13);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R4 illegal code", cfg_err, 1);
    wr(3, 8); wr(7, 12);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R4 inactive queue ignored", cfg_err, 0);
    wr(7, 8);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      pend = $urandom();
      if ($urandom_range(0, 49) == 0) num_q = 6'($urandom_range(1, NQ));
      if ($urandom_range(0, 3) == 0) begin
        cfg_we = 1'b1;
        cfg_qid = 5'($urandom_range(0, NQ - 1));
        cfg_prio = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(10, 15))
                                               : 4'($urandom_range(0, 9));
      end else cfg_we = 1'b0;
    end
    @(negedge clk); cfg_we = 1'b0; pend = '0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule